// File: doc/BRIEF.md
# Storage-Clear Sequencer

This block turns a long press on an active-low pushbutton into a complete fill of the general-purpose storage RAM. The button is first passed through a two-stage synchronizer. A hold counter then measures how long the button stays low while main power is good. The request is accepted only after an unbroken hold of 125 ms. The hold limit is worked out from the clock frequency and the hold time, which are both parameters.

Once the request is accepted, a sequencer drives the RAM write port. It writes the fill byte 0xFF once per clock into each of the 242 storage bytes, in ascending address order. Addresses below the storage base belong to the clock and control registers, and the block never addresses them. A press starts at most one fill. The button must be released before another fill can be armed.

If main power fails during a fill, writes stop at once and the fill is abandoned.

Top module: `storclr_seq`

## Requirements
- R1: A fill starts only after the synchronized button has been low for HOLD_CYCLES consecutive clocks (CLK_HZ*HOLD_MS/1000) with power good. Counted from the first clock edge that samples the button low, `busy_o` rises after exactly HOLD_CYCLES+SYNC_STAGES edges. A press sampled low for fewer than HOLD_CYCLES edges starts nothing.
- R2: While `pwr_good` is low, no press is recognized, however long it lasts.
- R3: The hold count restarts from zero whenever the synchronized button goes high or `pwr_good` goes low, even for a single clock.
- R4: One press starts at most one fill, however long the button is held. A new fill needs the button to be released and then pressed again.
- R5: Every write (`ram_we_o` = 1) addresses the range BASE_ADDR to BASE_ADDR+STORE_BYTES-1 inclusive. With the defaults that is 14 to 255. Addresses below BASE_ADDR, where the clock and control registers live, are never written.
- R6: A fill writes one byte per clock. The first write goes to BASE_ADDR, and each later write goes to the previous address plus one.
- R7: Every write carries the data byte 0xFF.
- R8: `busy_o` stays high for exactly STORE_BYTES clocks. During that time it writes every storage byte once, then drops after the write to the last address.
- R9: If `pwr_good` falls during a fill, `ram_we_o` goes low in the same cycle and `busy_o` goes low at the next edge. The fill does not resume when power returns.
- R10: After reset, `busy_o` = 0, `ram_we_o` = 0 and `ram_addr_o` = BASE_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_btn_n | input | 1 | Clear pushbutton, low while pressed, asynchronous |
| pwr_good | input | 1 | Main supply valid, synchronous level |
| ram_addr_o | output | ADDR_W | Storage RAM write address |
| ram_wdata_o | output | DATA_W | Storage RAM write data |
| ram_we_o | output | 1 | Storage RAM write enable |
| busy_o | output | 1 | Fill in progress |

## Verification
A hold counter that is off by even one cycle changes when `busy_o` rises. It can also make presses one cycle shorter than the limit start a fill. A sweep of every press length around the limit shows either fault within a few cycles of release. A wrong address register shows up on the very next write as a skipped step, a repeated step, or a step outside the storage window. A wrong end condition shows up within STORE_BYTES cycles as the wrong write count. An arming flag that never clears shows up as a second fill during one long hold.

// File: rtl/storclr_pkg.sv
package storclr_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_FILL = 1'b1
    } fill_phase_e;

    // Number of clock cycles in a hold of hold_ms milliseconds, at least one.
    function automatic int hold_cycles(input longint clk_hz, input longint hold_ms);
        longint n;
        n = (clk_hz * hold_ms) / 1000;
        if (n < 1) n = 1;
        return int'(n);
    endfunction

endpackage

// File: rtl/storclr_hold.sv
module storclr_hold #(
    parameter int HOLD_CYCLES = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    input  logic pwr_good,
    output logic fire_o
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   armed;
    } hold_t;

    hold_t st_q, st_d;
    logic  btn_low;
    logic  qual;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], btn_n};
        btn_low   = ~st_q.sync[SYNC_STAGES-1];
        qual      = btn_low & pwr_good;

        // Consecutive qualified cycles, saturating at the limit.
        if (!qual) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_SAT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        fire_o = st_q.armed & qual & (st_q.cnt == CNT_FIRE);

        // Release re-arms; a recognized press disarms until release.
        if (!btn_low) begin
            st_d.armed = 1'b1;
        end else if (fire_o) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync  <= '1;
            st_q.cnt   <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/storclr_fill.sv
module storclr_fill #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int BASE_ADDR   = 14,
    parameter int STORE_BYTES = 242,
    parameter int FILL_VALUE  = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pwr_good,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              we_o,
    output logic              busy_o
);
    import storclr_pkg::*;

    localparam logic [ADDR_W-1:0] FIRST_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] LAST_ADDR  = ADDR_W'(BASE_ADDR + STORE_BYTES - 1);

    typedef struct packed {
        fill_phase_e       phase;
        logic [ADDR_W-1:0] addr;
    } fill_t;

    fill_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i && pwr_good) begin
                    st_d.phase = PH_FILL;
                    st_d.addr  = FIRST_ADDR;
                end
            end
            PH_FILL: begin
                if (!pwr_good || st_q.addr == LAST_ADDR) begin
                    st_d.phase = PH_IDLE;
                    st_d.addr  = FIRST_ADDR;
                end else begin
                    st_d.addr = st_q.addr + 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.addr  = FIRST_ADDR;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.addr  <= FIRST_ADDR;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.phase == PH_FILL);
    assign we_o   = busy_o & pwr_good;
    assign addr_o = st_q.addr;
    assign data_o = DATA_W'(FILL_VALUE);

endmodule

// File: rtl/storclr_seq.sv
module storclr_seq #(
    parameter int CLK_HZ      = 32768,
    parameter int HOLD_MS     = 125,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int BASE_ADDR   = 14,
    parameter int STORE_BYTES = 242,
    parameter int FILL_VALUE  = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_btn_n,
    input  logic              pwr_good,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    output logic              ram_we_o,
    output logic              busy_o
);
    localparam int HOLD_CYCLES = storclr_pkg::hold_cycles(CLK_HZ, HOLD_MS);

    logic fire;

    storclr_hold #(
        .HOLD_CYCLES (HOLD_CYCLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_n    (clr_btn_n),
        .pwr_good (pwr_good),
        .fire_o   (fire)
    );

    storclr_fill #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .BASE_ADDR   (BASE_ADDR),
        .STORE_BYTES (STORE_BYTES),
        .FILL_VALUE  (FILL_VALUE)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (fire),
        .pwr_good (pwr_good),
        .addr_o   (ram_addr_o),
        .data_o   (ram_wdata_o),
        .we_o     (ram_we_o),
        .busy_o   (busy_o)
    );

endmodule

// File: rtl/storclr_seq_chk.sv
module storclr_seq_chk #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int BASE_ADDR   = 14,
    parameter int STORE_BYTES = 242,
    parameter int FILL_VALUE  = 255
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_good,
    input logic [ADDR_W-1:0] ram_addr_o,
    input logic [DATA_W-1:0] ram_wdata_o,
    input logic              ram_we_o,
    input logic              busy_o
);
    localparam logic [ADDR_W-1:0] FIRST_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] LAST_ADDR  = ADDR_W'(BASE_ADDR + STORE_BYTES - 1);
    localparam logic [DATA_W-1:0] FILL_BYTE  = DATA_W'(FILL_VALUE);

    assert_write_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_addr_o >= FIRST_ADDR && ram_addr_o <= LAST_ADDR));

    assert_start_at_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ram_addr_o == FIRST_ADDR);

    assert_ascending_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_o && $past(ram_we_o)) |-> ram_addr_o == $past(ram_addr_o) + 1'b1);

    assert_fill_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> ram_wdata_o == FILL_BYTE);

    assert_end_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && $past(pwr_good)) |-> $past(ram_addr_o) == LAST_ADDR);

    assert_abort_on_power_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !pwr_good) |=> !busy_o);

    assert_start_needs_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(pwr_good));

endmodule

bind storclr_seq storclr_seq_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .BASE_ADDR   (BASE_ADDR),
    .STORE_BYTES (STORE_BYTES),
    .FILL_VALUE  (FILL_VALUE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_we_o    (ram_we_o),
    .busy_o      (busy_o)
);

// File: tb/storclr_seq_tb.sv
module storclr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 160;
    localparam int HOLD_MS    = 125;
    localparam int HOLD       = CLK_HZ * HOLD_MS / 1000;   // 20
    localparam int SYNC       = 2;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int BASE       = 14;
    localparam int BYTES      = 242;
    localparam int LAST       = BASE + BYTES - 1;
    localparam int SETTLE     = BYTES + SYNC + 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr_btn_n = 1'b1;
    logic              pwr_good = 1'b1;
    logic [ADDR_W-1:0] ram_addr_o;
    logic [DATA_W-1:0] ram_wdata_o;
    logic              ram_we_o;
    logic              busy_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    storclr_seq #(
        .CLK_HZ      (CLK_HZ),
        .HOLD_MS     (HOLD_MS),
        .SYNC_STAGES (SYNC),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .BASE_ADDR   (BASE),
        .STORE_BYTES (BYTES),
        .FILL_VALUE  (255)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_btn_n   (clr_btn_n),
        .pwr_good    (pwr_good),
        .ram_addr_o  (ram_addr_o),
        .ram_wdata_o (ram_wdata_o),
        .ram_we_o    (ram_we_o),
        .busy_o      (busy_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int c0 = 0;
    int fills = 0;
    int rise_cyc = 0;
    int exp_addr = 0;
    int wr_in_fill = 0;
    int last_fill_writes = 0;
    bit abort_ok = 1'b0;
    bit busy_prev = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: a quarter period after each falling edge, clear of both edges.
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (rst_n) begin
            if (busy_o && !busy_prev) begin
                fills++;
                rise_cyc   = cyc;
                exp_addr   = BASE;
                wr_in_fill = 0;
            end
            if (ram_we_o) begin
                chk(int'(ram_addr_o) == exp_addr, "R6 address step", int'(ram_addr_o), exp_addr);
                chk(int'(ram_addr_o) >= BASE && int'(ram_addr_o) <= LAST,
                    "R5 address window", int'(ram_addr_o), BASE);
                chk(ram_wdata_o == 8'hFF, "R7 fill byte", int'(ram_wdata_o), 255);
                exp_addr++;
                wr_in_fill++;
            end
            if (!busy_o && busy_prev) begin
                last_fill_writes = wr_in_fill;
                if (!abort_ok)
                    chk(wr_in_fill == BYTES, "R8 writes per fill", wr_in_fill, BYTES);
            end
            busy_prev = busy_o;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Button low for exactly len sampling edges, then released.
    task automatic press(input int len);
        @(negedge clk);
        clr_btn_n = 1'b0;
        c0 = cyc;
        repeat (len) @(negedge clk);
        clr_btn_n = 1'b1;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int f0;
        int wr_at_drop;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        // R10 reset state
        chk(busy_o == 1'b0, "R10 busy after reset", int'(busy_o), 0);
        chk(ram_we_o == 1'b0, "R10 we after reset", int'(ram_we_o), 0);
        chk(int'(ram_addr_o) == BASE, "R10 addr after reset", int'(ram_addr_o), BASE);
        idle(4);

        // R1 sweep of press lengths around the hold limit
        for (int len = 1; len <= HOLD + 3; len++) begin
            f0 = fills;
            press(len);
            idle(SETTLE);
            chk((fills - f0) == ((len >= HOLD) ? 1 : 0), "R1 press length vs fill",
                fills - f0, (len >= HOLD) ? 1 : 0);
            if (len >= HOLD)
                chk(rise_cyc - c0 == HOLD + SYNC, "R1 recognition latency",
                    rise_cyc - c0, HOLD + SYNC);
            idle(3);
        end

        // R2 long press with power absent
        pwr_good = 1'b0;
        f0 = fills;
        press(3 * HOLD);
        idle(SETTLE);
        chk(fills == f0, "R2 no fill without power", fills - f0, 0);
        chk(ram_we_o == 1'b0, "R2 no write without power", int'(ram_we_o), 0);
        pwr_good = 1'b1;
        idle(3);

        // R3 one-cycle power dip restarts the count
        f0 = fills;
        @(negedge clk);
        clr_btn_n = 1'b0;
        idle(HOLD - 4);
        pwr_good = 1'b0;
        @(negedge clk);
        pwr_good = 1'b1;
        idle(HOLD / 2);
        clr_btn_n = 1'b1;
        idle(SETTLE);
        chk(fills == f0, "R3 power dip restarts count", fills - f0, 0);

        // R3 one-cycle bounce high restarts the count
        f0 = fills;
        @(negedge clk);
        clr_btn_n = 1'b0;
        idle(HOLD - 4);
        clr_btn_n = 1'b1;
        @(negedge clk);
        clr_btn_n = 1'b0;
        idle(HOLD / 2);
        clr_btn_n = 1'b1;
        idle(SETTLE);
        chk(fills == f0, "R3 bounce restarts count", fills - f0, 0);

        // R3 after a dip, a full hold is honoured again
        f0 = fills;
        @(negedge clk);
        clr_btn_n = 1'b0;
        idle(HOLD - 4);
        pwr_good = 1'b0;
        @(negedge clk);
        pwr_good = 1'b1;
        idle(HOLD + 6);
        clr_btn_n = 1'b1;
        idle(SETTLE);
        chk(fills - f0 == 1, "R3 full hold after dip", fills - f0, 1);

        // R4 one fill per press, re-armed by release
        f0 = fills;
        press(3 * HOLD + BYTES + 20);
        idle(SETTLE);
        chk(fills - f0 == 1, "R4 single fill on long hold", fills - f0, 1);
        f0 = fills;
        press(HOLD);
        idle(SETTLE);
        chk(fills - f0 == 1, "R4 re-armed after release", fills - f0, 1);

        // R9 power loss during a fill
        f0 = fills;
        press(HOLD);
        idle(SYNC + 50);
        chk(busy_o == 1'b1, "R9 fill running before dip", int'(busy_o), 1);
        abort_ok = 1'b1;
        wr_at_drop = wr_in_fill;
        pwr_good = 1'b0;
        #1;
        chk(ram_we_o == 1'b0, "R9 write stops at once", int'(ram_we_o), 0);
        @(negedge clk);
        #(CLK_PERIOD/4 + 1);
        chk(busy_o == 1'b0, "R9 busy drops next edge", int'(busy_o), 1'b0);
        idle(5);
        pwr_good = 1'b1;
        idle(SETTLE);
        chk(fills - f0 == 1, "R9 no resume after power return", fills - f0, 1);
        chk(last_fill_writes == wr_at_drop, "R9 writes before dip", last_fill_writes, wr_at_drop);
        abort_ok = 1'b0;

        // R8 a normal fill after the abort completes in full
        f0 = fills;
        press(HOLD + 1);
        idle(SETTLE);
        chk(fills - f0 == 1, "R8 fill after abort", fills - f0, 1);
        chk(last_fill_writes == BYTES, "R8 full byte count", last_fill_writes, BYTES);
        chk(int'(ram_addr_o) == BASE && !busy_o, "R10 idle state after fill",
            int'(ram_addr_o), BASE);

        summary();
        $finish;
    end

endmodule